// File: doc/BRIEF.md
# Two-Level Active-Set Warp Scheduler

This block picks which warp issues next in a multithreaded core. It tracks a pool of warps and lets only a small active set of them compete for issue. Each cycle it looks at the per-warp ready flags of the warps in the active set. It picks one in round-robin order by active slot, and it presents that warp's ID with a valid flag. The pipeline accepts the offer with a grant.

When a granted instruction is marked as a possible long-latency operation, such as a global load, the warp is demoted. It leaves its active slot, a one-cycle deschedule pulse carries its ID to neighbouring logic such as a register cache, and the warp waits for its completion report. Once the completion arrives, the warp joins the back of a promotion queue. Whenever an active slot is free, the warp at the head of that queue is moved into the lowest-numbered free slot.

At reset, warps 0 to NUM_SLOTS-1 occupy slots 0 to NUM_SLOTS-1 in that order. The remaining warps wait in the promotion queue in increasing ID order. With the defaults, 8 of 32 warps are active, which is 256 of 1024 threads.

Top module: `warp_twolevel_sched`

## Requirements
- R1: After reset, slot i holds warp i for every slot, the promotion queue holds the remaining warps in increasing ID order, and `desched_valid_o` is low.
- R2: `issue_valid_o` is high only when some active warp has its `warp_ready_i` bit set, and `issue_wid_o` is then always an active, ready warp. With no active ready warp, `issue_valid_o` is low.
- R3: The offered warp is the one in the first slot, scanning upward with wrap-around, after the slot that last received a grant. The scan starts from the slot after slot NUM_SLOTS-1 (that is, slot 0) after reset.
- R4: A grant with `issue_long_i` high removes the warp from its slot at that clock edge. The warp is not offered again until its completion has arrived and it has been promoted.
- R5: A grant with `issue_long_i` high makes `desched_valid_o` high for exactly the following cycle, with `desched_wid_o` equal to the demoted warp's ID.
- R6: A completion (`cmpl_valid_i` with `cmpl_wid_i`) for a warp that is waiting appends that warp to the back of the promotion queue at the clock edge. A completion for a warp that is active or already queued has no effect.
- R7: At each clock edge where a slot is free and the queue is not empty, the queue head moves into the lowest-numbered free slot, at most one warp per edge. A slot freed at one edge can be refilled at the next edge at the earliest.
- R8: An offer without a grant changes no state: the round-robin position, the active set and the queue stay as they were.
- R9: `issue_long_i` has no effect in a cycle without a grant: no demotion and no deschedule pulse follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready_i | input | NUM_WARPS | Per-warp ready flag, bit n for warp n |
| issue_grant_i | input | 1 | Pipeline accepts the offered warp this cycle |
| issue_long_i | input | 1 | The granted instruction may have long latency |
| cmpl_valid_i | input | 1 | A long-latency operation finished this cycle |
| cmpl_wid_i | input | log2(NUM_WARPS) | Warp whose operation finished |
| issue_valid_o | output | 1 | A warp is offered for issue |
| issue_wid_o | output | log2(NUM_WARPS) | ID of the offered warp |
| desched_valid_o | output | 1 | One-cycle pulse: a warp was demoted at the last edge |
| desched_wid_o | output | log2(NUM_WARPS) | ID of the demoted warp |

## Verification
A wrong slot table or a wrong round-robin pointer shows up at once, in the first cycle where the affected slot's warp is ready: the offered ID differs from the one a slot-by-slot model predicts. A corrupted promotion queue or warp-state entry surfaces more slowly. It appears only when the affected warp should have been promoted, or when a stray completion wrongly revives it. So the bench runs long random stretches with frequent demotions and completions for warps that are not waiting, and it compares the offered ID and the deschedule pulse with a behavioural model every cycle.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    localparam int unsigned WS_NUM_WARPS = 32;
    localparam int unsigned WS_NUM_SLOTS = 8;

    typedef enum logic [1:0] {
        WST_ACTIVE = 2'd0,
        WST_WAIT   = 2'd1,
        WST_QUEUED = 2'd2
    } wstate_e;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 == n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= int'(N); k++) begin
            if (!gnt_vld && req[(int'(last) + k) % int'(N)]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'((int'(last) + k) % int'(N));
            end
        end
    end
endmodule

// File: rtl/wsched_active_tbl.sv
module wsched_active_tbl #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned WID_W     = 5,
    parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clr_en,
    input  logic [SLOT_W-1:0]                 clr_idx,
    input  logic                              set_en,
    input  logic [WID_W-1:0]                  set_wid,
    output logic [NUM_SLOTS-1:0]              slot_vld,
    output logic [NUM_SLOTS-1:0][WID_W-1:0]   slot_wid,
    output logic                              free_vld,
    output logic [SLOT_W-1:0]                 free_idx
);
    // lowest free slot
    always_comb begin
        free_vld = 1'b0;
        free_idx = '0;
        for (int s = int'(NUM_SLOTS) - 1; s >= 0; s--) begin
            if (!slot_vld[s]) begin
                free_vld = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_vld[s] <= 1'b1;
                    slot_wid[s] <= WID_W'(s);
                end else begin
                    if (clr_en && clr_idx == SLOT_W'(s)) begin
                        slot_vld[s] <= 1'b0;
                    end
                    if (set_en && free_idx == SLOT_W'(s)) begin
                        slot_vld[s] <= 1'b1;
                        slot_wid[s] <= set_wid;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wsched_promo_q.sv
module wsched_promo_q
    import wsched_pkg::*;
#(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned DW         = 5,
    parameter int unsigned INIT_FIRST = 8,
    parameter int unsigned INIT_CNT   = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [DW-1:0] push_data,
    input  logic          pop_en,
    output logic [DW-1:0] head,
    output logic          nonempty
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    assign head     = mem[rd_ptr];
    assign nonempty = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= (i < int'(INIT_CNT)) ? DW'(int'(INIT_FIRST) + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PW'(INIT_CNT % DEPTH);
            cnt    <= CW'(INIT_CNT);
        end else begin
            if (push_en) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
            end
            if (pop_en) begin
                rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
            end
            if (push_en && !pop_en) begin
                cnt <= cnt + CW'(1);
            end else if (!push_en && pop_en) begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/warp_twolevel_sched.sv
module warp_twolevel_sched
    import wsched_pkg::*;
#(
    parameter int unsigned NUM_WARPS = WS_NUM_WARPS,
    parameter int unsigned NUM_SLOTS = WS_NUM_SLOTS,
    parameter int unsigned WID_W     = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] warp_ready_i,
    input  logic                 issue_grant_i,
    input  logic                 issue_long_i,
    input  logic                 cmpl_valid_i,
    input  logic [WID_W-1:0]     cmpl_wid_i,
    output logic                 issue_valid_o,
    output logic [WID_W-1:0]     issue_wid_o,
    output logic                 desched_valid_o,
    output logic [WID_W-1:0]     desched_wid_o
);
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0]            slot_vld;
    logic [NUM_SLOTS-1:0][WID_W-1:0] slot_wid;
    logic [NUM_SLOTS-1:0]            slot_req;
    logic                            free_vld;
    logic [SLOT_W-1:0]               free_idx;
    logic                            pick_vld;
    logic [SLOT_W-1:0]               pick_idx;
    logic [SLOT_W-1:0]               last_slot;
    logic [WID_W-1:0]                q_head;
    logic                            q_nonempty;
    wstate_e                         wstate [NUM_WARPS];

    logic issue_fire;
    logic demote;
    logic cmpl_ok;
    logic promote;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
            assign slot_req[s] = slot_vld[s] & warp_ready_i[slot_wid[s]];
        end
    endgenerate

    wsched_rr_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
        .req     (slot_req),
        .last    (last_slot),
        .gnt_vld (pick_vld),
        .gnt_idx (pick_idx)
    );

    assign issue_valid_o = pick_vld;
    assign issue_wid_o   = slot_wid[pick_idx];

    assign issue_fire = pick_vld & issue_grant_i;
    assign demote     = issue_fire & issue_long_i;
    assign cmpl_ok    = cmpl_valid_i & (wstate[cmpl_wid_i] == WST_WAIT);
    assign promote    = free_vld & q_nonempty;

    wsched_active_tbl #(.NUM_SLOTS(NUM_SLOTS), .WID_W(WID_W), .SLOT_W(SLOT_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (demote),
        .clr_idx  (pick_idx),
        .set_en   (promote),
        .set_wid  (q_head),
        .slot_vld (slot_vld),
        .slot_wid (slot_wid),
        .free_vld (free_vld),
        .free_idx (free_idx)
    );

    wsched_promo_q #(
        .DEPTH      (NUM_WARPS),
        .DW         (WID_W),
        .INIT_FIRST (NUM_SLOTS),
        .INIT_CNT   (NUM_WARPS - NUM_SLOTS)
    ) u_q (
        .clk       (clk),
        .rst       (rst),
        .push_en   (cmpl_ok),
        .push_data (cmpl_wid_i),
        .pop_en    (promote),
        .head      (q_head),
        .nonempty  (q_nonempty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_slot       <= SLOT_W'(NUM_SLOTS - 1);
            desched_valid_o <= 1'b0;
            desched_wid_o   <= '0;
        end else begin
            if (issue_fire) begin
                last_slot <= pick_idx;
            end
            desched_valid_o <= demote;
            if (demote) begin
                desched_wid_o <= issue_wid_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < int'(NUM_WARPS); w++) begin
                wstate[w] <= (w < int'(NUM_SLOTS)) ? WST_ACTIVE : WST_QUEUED;
            end
        end else begin
            if (demote) begin
                wstate[issue_wid_o] <= WST_WAIT;
            end
            if (cmpl_ok) begin
                wstate[cmpl_wid_i] <= WST_QUEUED;
            end
            if (promote) begin
                wstate[q_head] <= WST_ACTIVE;
            end
        end
    end
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
    parameter int unsigned NUM_WARPS = 32,
    parameter int unsigned WID_W     = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] warp_ready_i,
    input logic                 issue_grant_i,
    input logic                 issue_long_i,
    input logic                 issue_valid_o,
    input logic [WID_W-1:0]     issue_wid_o,
    input logic                 desched_valid_o,
    input logic [WID_W-1:0]     desched_wid_o
);
    AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o |-> warp_ready_i[issue_wid_o]); // R2

    AST_IDLE_WHEN_NONE_READY: assert property (@(posedge clk) disable iff (rst)
        (warp_ready_i == '0) |-> !issue_valid_o); // R2

    AST_DEMOTED_NOT_OFFERED: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && issue_grant_i && issue_long_i) |=>
            !(issue_valid_o && issue_wid_o == $past(issue_wid_o))); // R4

    AST_DESCHED_FOLLOWS_LONG: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_o && issue_grant_i && issue_long_i) |=>
            (desched_valid_o && desched_wid_o == $past(issue_wid_o))); // R5

    AST_DESCHED_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
        desched_valid_o |-> $past(issue_valid_o && issue_grant_i && issue_long_i)); // R9
endmodule

bind warp_twolevel_sched wsched_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .warp_ready_i    (warp_ready_i),
    .issue_grant_i   (issue_grant_i),
    .issue_long_i    (issue_long_i),
    .issue_valid_o   (issue_valid_o),
    .issue_wid_o     (issue_wid_o),
    .desched_valid_o (desched_valid_o),
    .desched_wid_o   (desched_wid_o)
);

// File: tb/warp_twolevel_sched_tb.sv
`timescale 1ns/1ps
module warp_twolevel_sched_tb;
    localparam int NW = 32;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] ready = '0;
    logic          grant = 1'b0;
    logic          lng = 1'b0;
    logic          cv = 1'b0;
    logic [4:0]    cw = '0;
    logic          issue_valid_o;
    logic [4:0]    issue_wid_o;
    logic          desched_valid_o;
    logic [4:0]    desched_wid_o;

    always #5 clk = ~clk;

    warp_twolevel_sched u_dut (
        .clk             (clk),
        .rst             (rst),
        .warp_ready_i    (ready),
        .issue_grant_i   (grant),
        .issue_long_i    (lng),
        .cmpl_valid_i    (cv),
        .cmpl_wid_i      (cw),
        .issue_valid_o   (issue_valid_o),
        .issue_wid_o     (issue_wid_o),
        .desched_valid_o (desched_valid_o),
        .desched_wid_o   (desched_wid_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model: 0 active, 1 waiting, 2 queued
    int m_slot_w [NS];
    bit m_slot_v [NS];
    int m_st [NW];
    int m_q [$];
    int m_last;
    bit m_dv;
    int m_dw;
    bit e_v;
    int e_s;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_slot_w[s] = s;
            m_slot_v[s] = 1;
        end
        m_q.delete();
        for (int w = 0; w < NW; w++) begin
            m_st[w] = (w < NS) ? 0 : 2;
            if (w >= NS) m_q.push_back(w);
        end
        m_last = NS - 1;
        m_dv = 0;
        m_dw = 0;
    endtask

    task automatic model_pick();
        e_v = 0;
        e_s = 0;
        for (int k = 1; k <= NS; k++) begin
            if (!e_v && m_slot_v[(m_last + k) % NS] && ready[m_slot_w[(m_last + k) % NS]]) begin
                e_v = 1;
                e_s = (m_last + k) % NS;
            end
        end
    endtask

    // apply inputs at negedge, then compare outputs
    task automatic drive(input logic [NW-1:0] r, input bit g, input bit l, input bit c, input int w);
        @(negedge clk);
        ready = r; grant = g; lng = l; cv = c; cw = 5'(w);
        #1;
        model_pick();
        chk("R2/R3 issue_valid", int'(issue_valid_o), int'(e_v));
        if (e_v) chk("R3/R4/R6/R7 issue_wid", int'(issue_wid_o), m_slot_w[e_s]);
        chk("R5/R9 desched_valid", int'(desched_valid_o), int'(m_dv));
        if (m_dv) chk("R5 desched_wid", int'(desched_wid_o), m_dw);
    endtask

    task automatic advance();
        bit fire, dem, prom, cok;
        int free_s, head, w;
        @(posedge clk);
        model_pick();
        fire = e_v && grant;
        dem = fire && lng;
        w = e_v ? m_slot_w[e_s] : 0;
        free_s = -1;
        for (int s = NS - 1; s >= 0; s--) if (!m_slot_v[s]) free_s = s;
        prom = (free_s >= 0) && (m_q.size() > 0);
        head = prom ? m_q[0] : 0;
        cok = cv && (m_st[cw] == 1);
        if (fire) m_last = e_s;
        m_dv = dem;
        if (dem) begin
            m_dw = w;
            m_slot_v[e_s] = 0;
            m_st[w] = 1;
        end
        if (prom) begin
            void'(m_q.pop_front());
            m_slot_v[free_s] = 1;
            m_slot_w[free_s] = head;
            m_st[head] = 0;
        end
        if (cok) begin
            m_q.push_back(int'(cw));
            m_st[cw] = 2;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] rr;
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents seen through single-ready sweeps, no grants
        for (int k = 0; k < NS; k++) begin
            drive(NW'(1) << k, 0, 0, 0, 0);
            chk("R1 slot holds warp", int'(issue_wid_o), k);
            advance();
        end
        drive(NW'(1) << NS, 0, 0, 0, 0);
        chk("R1/R2 queued warp not offered", int'(issue_valid_o), 0);
        chk("R1 desched low", int'(desched_valid_o), 0);
        advance();

        // R8 / R9: offers without grant leave the pointer and set alone
        drive('1, 0, 1, 0, 0);
        chk("R3 first offer slot 0", int'(issue_wid_o), 0);
        advance();
        drive('1, 1, 0, 0, 0);
        chk("R8 pointer unchanged without grant", int'(issue_wid_o), 0);
        chk("R9 no pulse after ungranted long", int'(desched_valid_o), 0);
        advance();
        drive('1, 1, 1, 0, 0);
        chk("R3 rotates to next slot", int'(issue_wid_o), 1);
        advance();
        drive(NW'(1) << 1, 0, 0, 0, 0);
        chk("R5 pulse after long grant", int'(desched_valid_o), 1);
        chk("R5 pulse carries warp", int'(desched_wid_o), 1);
        chk("R4 demoted warp not offered", int'(issue_valid_o), 0);
        advance();
        drive(NW'(1) << NS, 0, 0, 1, 1);
        chk("R7 queue head fills freed slot", int'(issue_valid_o), 1);
        chk("R7 promoted warp id", int'(issue_wid_o), NS);
        chk("R5 pulse lasts one cycle", int'(desched_valid_o), 0);
        advance();
        drive('1, 0, 0, 1, 3);   // R6: completion for an active warp
        advance();

        // random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            rr = '0;
            for (int b = 0; b < NW; b++) rr[b] = ($urandom % 10) < 6;
            drive(rr, ($urandom % 4) != 0, ($urandom % 3) == 0,
                  ($urandom % 2) == 0, int'($urandom % NW));
            advance();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule